// File: doc/BRIEF.md
# Discrete-Input Serial Register Interface

This block is the digital side of an eight-channel discrete sensor front end. A serial slave port with chip select, serial clock, data in, data out and a register-select pin gives access to two registers. The snapshot register takes the eight channel states at the moment chip select goes low, and a read shifts them out. The 9-bit setup register holds one mode bit per channel and a self-test enable bit. It drives a pull-up enable and a pull-down enable for each channel.

All serial pins and channel inputs pass through synchronizers into the block's system clock domain, so the block needs a system clock several times faster than the serial clock. SI is sampled on the rising serial clock edge. SO changes on the falling edge. SO is taken from the end of the active shift chain, so devices can be daisy-chained. While self-test is enabled, the snapshot takes the channel mode bits in place of the channel inputs, which lets the host compare what it reads with what it wrote.

Top module: `discrete_spi_regs`

## Requirements
- R1: After reset, so and so_oe are 0, every pu_en and pd_en bit is 0, and test_en is 0.
- R2: All pu_en and pd_en bits stay 0 until the first accepted setup-register write. Snapshot reads do not change this.
- R3: sel sampled high when cs_n falls selects the snapshot path. The snapshot holds the channel states seen at that fall, and later input changes during the transfer do not appear on so.
- R4: A snapshot read shifts out chan_in[7] first and chan_in[0] last.
- R5: A setup write shifts 9 bits with sel low, most significant first. Bit 8 is test enable and bits 7..0 are the modes of channels 8..1. The register is loaded on the rise of cs_n, and only when at least 9 serial clocks were given. When more than 9 are given, the last 9 bits shifted in are kept.
- R6: A setup transfer with fewer than 9 serial clocks leaves the register and all enables unchanged.
- R7: During a setup transfer, the previous register contents appear on so first, bit 8 first.
- R8: Bits entering on si leave on so after 8 clocks on the snapshot path and after 9 clocks on the setup path.
- R9: A mode bit of 1 gives pu_en=1 and pd_en=0 for that channel. A mode bit of 0 gives pu_en=0 and pd_en=1. Both are never 1 together.
- R10: When bit 8 is 1, test_en is 1 and the snapshot captures mode bits 7..0 instead of chan_in.
- R11: While cs_n is high, so and so_oe are 0. so_oe is 1 during a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| sel | input | 1 | Register select: 1 snapshot, 0 setup |
| si | input | 1 | Serial data in |
| chan_in | input | 8 | Channel logic states |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for so |
| pu_en | output | 8 | Per-channel pull-up switch enable |
| pd_en | output | 8 | Per-channel pull-down switch enable |
| test_en | output | 1 | Self-test mode active |

## Verification
The bench reads the snapshot before any setup write and checks that the enables stay off. A design that armed the switches at reset would fail this check. It changes the channel inputs in the middle of a read, which catches a design that samples live inputs instead of capturing them at the chip-select fall. It gives a 5-clock setup transfer, which exposes a design that commits partial writes. It gives 18- and 16-clock transfers, which expose a shift chain of the wrong length or order for daisy-chaining. It also enables self-test and reads back the mode bits, which catches a snapshot multiplexer that ignores the test bit.

// File: rtl/dspi_pkg.sv
package dspi_pkg;

    typedef enum logic {
        PATH_CFG  = 1'b0,
        PATH_DATA = 1'b1
    } path_e;

    typedef struct packed {
        logic cs_n;
        logic sck;
        logic sel;
        logic si;
    } spi_pins_t;

    localparam int PIN_W = 4;
    localparam logic [PIN_W-1:0] PIN_IDLE = 4'b1000;

    function automatic path_e sel_to_path(input logic sel);
        return sel ? PATH_DATA : PATH_CFG;
    endfunction

endpackage

// File: rtl/dspi_sync.sv
module dspi_sync #(
    parameter int W = 4,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/dspi_shift.sv
module dspi_shift
    import dspi_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  spi_pins_t      pins,
    input  logic [NCH-1:0] chan,
    output logic           so,
    output logic           so_oe,
    output logic [NCH:0]   cfg_q,
    output logic           cfg_written
);
    localparam int CFG_W = NCH + 1;
    localparam int CNT_W = $clog2(CFG_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CFG_W);

    logic             cs_d, sck_d, active;
    path_e            path_q;
    logic [NCH-1:0]   dat_sh, snap;
    logic [CFG_W-1:0] cfg_sh;
    logic [CNT_W-1:0] cnt;
    logic             cs_fall, cs_rise, sck_rise, sck_fall;

    assign cs_fall  = cs_d & ~pins.cs_n;
    assign cs_rise  = ~cs_d & pins.cs_n;
    assign sck_rise = ~sck_d & pins.sck;
    assign sck_fall = sck_d & ~pins.sck;
    // self-test substitutes the mode bits for the channel inputs
    assign snap     = cfg_q[NCH] ? cfg_q[NCH-1:0] : chan;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_d        <= 1'b1;
            sck_d       <= 1'b0;
            active      <= 1'b0;
            path_q      <= PATH_CFG;
            dat_sh      <= '0;
            cfg_sh      <= '0;
            cnt         <= '0;
            cfg_q       <= '0;
            cfg_written <= 1'b0;
            so          <= 1'b0;
            so_oe       <= 1'b0;
        end else begin
            cs_d  <= pins.cs_n;
            sck_d <= pins.sck;
            if (cs_fall) begin
                active <= 1'b1;
                so_oe  <= 1'b1;
                path_q <= sel_to_path(pins.sel);
                dat_sh <= snap;
                cfg_sh <= cfg_q;
                cnt    <= '0;
                so     <= pins.sel ? snap[NCH-1] : cfg_q[NCH];
            end else if (cs_rise) begin
                active <= 1'b0;
                so_oe  <= 1'b0;
                so     <= 1'b0;
                if (path_q == PATH_CFG && cnt == CNT_FULL) begin
                    cfg_q       <= cfg_sh;
                    cfg_written <= 1'b1;
                end
            end else if (active) begin
                if (sck_rise) begin
                    if (path_q == PATH_DATA) dat_sh <= {dat_sh[NCH-2:0], pins.si};
                    else                     cfg_sh <= {cfg_sh[CFG_W-2:0], pins.si};
                    if (cnt != CNT_FULL) cnt <= cnt + 1'b1;
                end else if (sck_fall) begin
                    so <= (path_q == PATH_DATA) ? dat_sh[NCH-1] : cfg_sh[CFG_W-1];
                end
            end
        end
    end

    // R5
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cs_rise |=> $stable(cfg_q));
    // R6
    short_write_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_rise && cnt != CNT_FULL) |=> $stable(cfg_q));
    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_FULL);
    // R11
    oe_on_chk: assert property (@(posedge clk) disable iff (rst)
        cs_fall |=> so_oe);
    // R11
    oe_off_chk: assert property (@(posedge clk) disable iff (rst)
        cs_rise |=> (!so_oe && !so));
endmodule

// File: rtl/dspi_switch.sv
module dspi_switch #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] mode,
    input  logic           armed,
    output logic [NCH-1:0] pu_en,
    output logic [NCH-1:0] pd_en
);
    for (genvar n = 0; n < NCH; n++) begin : g_chan
        assign pu_en[n] = armed &  mode[n];
        assign pd_en[n] = armed & ~mode[n];
    end

    // R9
    sw_excl_chk: assert property (@(posedge clk) disable iff (rst)
        (pu_en & pd_en) == '0);
    // R2
    sw_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !armed |-> (pu_en == '0 && pd_en == '0));
endmodule

// File: rtl/discrete_spi_regs.sv
module discrete_spi_regs
    import dspi_pkg::*;
#(
    parameter int NCH = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cs_n,
    input  logic           sck,
    input  logic           sel,
    input  logic           si,
    input  logic [NCH-1:0] chan_in,
    output logic           so,
    output logic           so_oe,
    output logic [NCH-1:0] pu_en,
    output logic [NCH-1:0] pd_en,
    output logic           test_en
);
    spi_pins_t      pins_raw, pins_s;
    logic [NCH-1:0] chan_s;
    logic [NCH:0]   cfg_q;
    logic           cfg_written;

    assign pins_raw = '{cs_n: cs_n, sck: sck, sel: sel, si: si};

    dspi_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) pin_sync_i (
        .clk(clk), .rst(rst), .d(pins_raw), .q(pins_s)
    );

    dspi_sync #(.W(NCH), .STAGES(SYNC_STAGES), .RST_VAL('0)) chan_sync_i (
        .clk(clk), .rst(rst), .d(chan_in), .q(chan_s)
    );

    dspi_shift #(.NCH(NCH)) shift_i (
        .clk(clk), .rst(rst), .pins(pins_s), .chan(chan_s),
        .so(so), .so_oe(so_oe), .cfg_q(cfg_q), .cfg_written(cfg_written)
    );

    dspi_switch #(.NCH(NCH)) switch_i (
        .clk(clk), .rst(rst), .mode(cfg_q[NCH-1:0]), .armed(cfg_written),
        .pu_en(pu_en), .pd_en(pd_en)
    );

    assign test_en = cfg_q[NCH];

    // R11
    so_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !so_oe |-> !so);
endmodule

// File: tb/discrete_spi_regs_tb.sv
module discrete_spi_regs_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 8;

    logic clk = 1'b0, rst = 1'b1;
    logic cs_n = 1'b1, sck = 1'b0, sel = 1'b0, si = 1'b0;
    logic [7:0] chan_in = 8'h00;
    logic so, so_oe, test_en;
    logic [7:0] pu_en, pd_en;

    int checks = 0, failures = 0;
    logic late_en = 1'b0;
    logic [7:0] late_val = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    discrete_spi_regs dut_i (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .sel(sel), .si(si),
        .chan_in(chan_in), .so(so), .so_oe(so_oe), .pu_en(pu_en),
        .pd_en(pd_en), .test_en(test_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic s, input int n, input logic [31:0] din,
                        output logic [31:0] dout);
        dout = '0;
        sel = s;
        wclk(4);
        cs_n = 1'b0;
        wclk(HALF);
        chk("R11 so_oe in transfer", {31'b0, so_oe}, 32'd1);
        if (late_en) chan_in = late_val;
        for (int i = 0; i < n; i++) begin
            si = din[n-1-i];
            wclk(HALF);
            dout = {dout[30:0], so};
            sck = 1'b1;
            wclk(HALF);
            sck = 1'b0;
        end
        wclk(HALF);
        cs_n = 1'b1;
        wclk(HALF);
        chk("R11 so idle", {30'b0, so, so_oe}, 32'd0);
    endtask

    task automatic t_reset();
        chk("R1 so/oe", {30'b0, so, so_oe}, 32'd0);
        chk("R1 pu", {24'b0, pu_en}, 32'd0);
        chk("R1 pd", {24'b0, pd_en}, 32'd0);
        chk("R1 test", {31'b0, test_en}, 32'd0);
    endtask

    task automatic t_read_unarmed();
        logic [31:0] d;
        chan_in = 8'hA5;
        wclk(4);
        xfer(1'b1, 8, 32'h0, d);
        chk("R4 read order", d, 32'hA5);
        chk("R2 pu off", {24'b0, pu_en}, 32'd0);
        chk("R2 pd off", {24'b0, pd_en}, 32'd0);
    endtask

    task automatic t_cfg_write();
        logic [31:0] d;
        xfer(1'b0, 9, 32'h03C, d);
        chk("R7 readback of reset value", d, 32'h000);
        chk("R9 pu", {24'b0, pu_en}, 32'h3C);
        chk("R9 pd", {24'b0, pd_en}, 32'hC3);
        chk("R5 test bit", {31'b0, test_en}, 32'd0);
    endtask

    task automatic t_cfg_chain();
        logic [31:0] d;
        xfer(1'b0, 18, {14'b0, 9'h1F0, 9'h0A5}, d);
        chk("R7 R8 chained config", d, {14'b0, 9'h03C, 9'h1F0});
        chk("R5 last 9 kept pu", {24'b0, pu_en}, 32'hA5);
        chk("R5 last 9 kept pd", {24'b0, pd_en}, 32'h5A);
    endtask

    task automatic t_short();
        logic [31:0] d;
        xfer(1'b0, 5, 32'h1F, d);
        chk("R6 short pu", {24'b0, pu_en}, 32'hA5);
        chk("R6 short test", {31'b0, test_en}, 32'd0);
        xfer(1'b0, 9, 32'h0A5, d);
        chk("R6 register kept", d, 32'h0A5);
    endtask

    task automatic t_data_chain();
        logic [31:0] d;
        chan_in = 8'h96;
        wclk(4);
        xfer(1'b1, 16, 32'hC35A, d);
        chk("R8 data chain", d, 32'h96C3);
    endtask

    task automatic t_capture();
        logic [31:0] d;
        chan_in = 8'h3C;
        wclk(4);
        late_en = 1'b1;
        late_val = 8'hFF;
        xfer(1'b1, 8, 32'h0, d);
        late_en = 1'b0;
        chk("R3 captured at cs fall", d, 32'h3C);
    endtask

    task automatic t_selftest();
        logic [31:0] d;
        xfer(1'b0, 9, 32'h169, d);
        chk("R10 test_en", {31'b0, test_en}, 32'd1);
        chan_in = 8'h00;
        wclk(4);
        xfer(1'b1, 8, 32'h0, d);
        chk("R10 snapshot of modes", d, 32'h69);
        xfer(1'b0, 9, 32'h0A5, d);
        chk("R10 test off", {31'b0, test_en}, 32'd0);
        chk("R9 restored pd", {24'b0, pd_en}, 32'h5A);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        wclk(5);
        rst = 1'b0;
        wclk(2);
        t_reset();
        t_read_unarmed();
        t_cfg_write();
        t_cfg_chain();
        t_short();
        t_data_chain();
        t_capture();
        t_selftest();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule